// File: doc/BRIEF.md
# Watchdog Fault Policy Controller

This block sits between a supervisor's watchdog and monitors and the reset, interrupt and operating-mode logic of a chip. It takes one-cycle fault events: watchdog overflow, missed trigger window, interrupt-service timeout and start-up timeout. It also takes a level-sensitive supply undervoltage flag. From these it issues one-cycle requests for reset, fail-safe entry and restart. It also keeps an interrupt flag and a 3-bit reset-cause code, and both are cleared by reading the status register.

A development latch relaxes the rules while firmware is brought up. While the latch is set, watchdog faults raise an interrupt in place of a reset and never request fail-safe. The reset cause is still recorded. Restart requests on undervoltage are still issued. An undervoltage that lasts through the qualification time still forces fail-safe. The latch can be set in two ways. Software can arm it once, early after power-on, before writing any other register. It is also set when the test pin is high on the first clock after power-on reset. It is cleared for good by any mode-register write that does not confirm it. In standby and sleep the latch has no effect.

Top module: `wdg_fault_policy`

## Requirements
- R1: With the development latch set and the operating mode normal (0) or restart (3), a watchdog fault does not pulse rst_req_o. It sets irq_flag_o on the next cycle.
- R2: rst_src_o holds a cause code: 0 none, 1 power-on, 2 overflow (wd_fault_i bit 0), 3 window (bit 1), 4 interrupt timeout (bit 2), 5 start-up timeout (bit 3), 6 undervoltage. The code reads 1 after reset. For simultaneous events the higher code wins, and undervoltage onset beats all watchdog faults. A status read (reg_re_i with address 2) clears the code to 0 when no new event arrives in the same cycle.
- R3: With the latch clear, a watchdog fault pulses rst_req_o for one cycle on the next cycle. If the operating mode is restart (3), failsafe_o also pulses.
- R4: With the latch set and the mode not standby or sleep, no watchdog fault causes failsafe_o, the restart mode included. restart_o is still issued on undervoltage onset.
- R5: When uv_i has been sampled high on UV_CYC consecutive clocks, failsafe_o pulses once in any mode, the development latch included.
- R6: A rising uv_i pulses rst_req_o and restart_o on the next cycle and records cause 6.
- R7: A write to address 0 with data bit 0 set arms the latch only if all three hold: it is the first write to address 0, no write to addresses 1 to 3 came before it, and fewer than START_CYC clocks have passed since reset.
- R8: test_pin_i high at the first clock after reset sets the latch. Its level at later clocks is ignored.
- R9: A write to address 1 (mode) sets the interrupt enable from data bit 1. This enable reads 1 after reset. The write keeps the latch only if data bit 0 is 1, and otherwise clears it even while test_pin_i is high.
- R10: Once cleared, the latch cannot be set again until the next reset.
- R11: With the mode standby (1) or sleep (2), watchdog faults follow the rules of R3 whatever the latch holds.
- R12: irq_o equals irq_flag_o gated by the interrupt enable. A status read clears irq_flag_o when no new fault arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| test_pin_i | input | 1 | Test pin level, sampled on the first clock after reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register address: 0 special, 1 mode, 2 status, 3 config |
| reg_wdata_i | input | 2 | Write data: bit 0 latch arm/confirm, bit 1 interrupt enable |
| op_mode_i | input | 2 | Operating mode: 0 normal, 1 standby, 2 sleep, 3 restart |
| wd_fault_i | input | 4 | Watchdog fault events: overflow, window, interrupt timeout, start-up timeout |
| uv_i | input | 1 | Supply undervoltage level |
| rst_req_o | output | 1 | Reset request pulse |
| irq_o | output | 1 | Interrupt, flag gated by enable |
| failsafe_o | output | 1 | Fail-safe entry request pulse |
| restart_o | output | 1 | Restart request pulse |
| dev_mode_o | output | 1 | Development latch state |
| irq_flag_o | output | 1 | Pending watchdog interrupt flag |
| rst_src_o | output | 3 | Reset cause code |

## Verification
Most internal faults in this block show up within one cycle of a stimulus. A wrong latch state shows as the wrong one of rst_req_o and irq_flag_o on the very next fault. A stale or mis-ordered cause code is visible on rst_src_o the cycle after the event. The arming window and the undervoltage qualifier are counters, and their faults appear later. An off-by-one or a failure to saturate is seen only when a write lands just past the window, or when failsafe_o arrives one cycle early or late, or twice, during a long undervoltage. Random fault vectors across all four operating modes, with the latch both set and clear, cover the routing and the cause priority.

// File: rtl/wfp_pkg.sv
package wfp_pkg;
  localparam int NUM_WF = 4;

  localparam logic [1:0] ADDR_SPECIAL = 2'd0;
  localparam logic [1:0] ADDR_MODE    = 2'd1;
  localparam logic [1:0] ADDR_STATUS  = 2'd2;
  localparam logic [1:0] ADDR_CFG     = 2'd3;

  localparam logic [2:0] SRC_NONE = 3'd0;
  localparam logic [2:0] SRC_POR  = 3'd1;
  localparam logic [2:0] SRC_OVF  = 3'd2;
  localparam logic [2:0] SRC_UV   = 3'd6;

  typedef enum logic [1:0] {
    OPM_NORMAL  = 2'd0,
    OPM_STANDBY = 2'd1,
    OPM_SLEEP   = 2'd2,
    OPM_RESTART = 2'd3
  } op_mode_e;
endpackage

// File: rtl/wfp_dev_latch.sv
module wfp_dev_latch
  import wfp_pkg::*;
#(
  parameter int START_CYC = 4_096_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       test_pin_i,
  input  logic       reg_we_i,
  input  logic [1:0] reg_addr_i,
  input  logic [1:0] reg_wdata_i,
  output logic       dev_q_o,
  output logic       irq_en_o
);
  localparam int SW = $clog2(START_CYC + 1);
  localparam logic [SW-1:0] SU_MAX = SW'(START_CYC);

  logic          por_seen;
  logic          arm_used;
  logic [SW-1:0] su_cnt;
  logic          arm_open;

  assign arm_open = !arm_used && (su_cnt < SU_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      por_seen <= 1'b0;
      arm_used <= 1'b0;
      su_cnt   <= '0;
      dev_q_o  <= 1'b0;
      irq_en_o <= 1'b1;
    end else begin
      por_seen <= 1'b1;
      if (su_cnt != SU_MAX) su_cnt <= su_cnt + 1'b1;
      if (!por_seen && test_pin_i) dev_q_o <= 1'b1;
      if (reg_we_i) begin
        arm_used <= 1'b1;  // any write consumes the one arming chance
        case (reg_addr_i)
          ADDR_SPECIAL: if (arm_open && reg_wdata_i[0]) dev_q_o <= 1'b1;
          ADDR_MODE: begin
            irq_en_o <= reg_wdata_i[1];
            if (!reg_wdata_i[0]) dev_q_o <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/wfp_uv_qual.sv
module wfp_uv_qual #(
  parameter int UV_CYC = 4_096_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic uv_i,
  output logic uv_rise_o,
  output logic uv_long_o
);
  localparam int UW = $clog2(UV_CYC + 1);
  localparam logic [UW-1:0] UV_MAX  = UW'(UV_CYC);
  localparam logic [UW-1:0] UV_LAST = UW'(UV_CYC - 1);

  logic          uv_q;
  logic [UW-1:0] uv_cnt;

  assign uv_rise_o = uv_i && !uv_q;
  assign uv_long_o = uv_i && (uv_cnt == UV_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      uv_q   <= 1'b0;
      uv_cnt <= '0;
    end else begin
      uv_q <= uv_i;
      if (!uv_i) uv_cnt <= '0;
      else if (uv_cnt != UV_MAX) uv_cnt <= uv_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wfp_fault_route.sv
module wfp_fault_route
  import wfp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_WF-1:0] wd_fault_i,
  input  logic [1:0]        op_mode_i,
  input  logic              dev_q_i,
  input  logic              uv_rise_i,
  input  logic              uv_long_i,
  input  logic              status_rd_i,
  output logic              rst_req_o,
  output logic              failsafe_o,
  output logic              restart_o,
  output logic              irq_flag_o,
  output logic [2:0]        rst_src_o
);
  logic       low_power, dev_eff, wd_any;
  logic [2:0] src_wd, src_d;

  assign low_power = (op_mode_i == OPM_STANDBY) || (op_mode_i == OPM_SLEEP);
  assign dev_eff   = dev_q_i && !low_power;
  assign wd_any    = |wd_fault_i;

  // higher index wins
  always_comb begin
    src_wd = SRC_NONE;
    for (int i = 0; i < NUM_WF; i++)
      if (wd_fault_i[i]) src_wd = SRC_OVF + 3'(i);
  end

  assign src_d = uv_rise_i ? SRC_UV : src_wd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_req_o  <= 1'b0;
      failsafe_o <= 1'b0;
      restart_o  <= 1'b0;
      irq_flag_o <= 1'b0;
      rst_src_o  <= SRC_POR;
    end else begin
      rst_req_o  <= uv_rise_i || (wd_any && !dev_eff);
      failsafe_o <= uv_long_i || (wd_any && !dev_eff && op_mode_i == OPM_RESTART);
      restart_o  <= uv_rise_i;
      if (wd_any && dev_eff) irq_flag_o <= 1'b1;
      else if (status_rd_i)  irq_flag_o <= 1'b0;
      if (wd_any || uv_rise_i) rst_src_o <= src_d;
      else if (status_rd_i)    rst_src_o <= SRC_NONE;
    end
  end
endmodule

// File: rtl/wdg_fault_policy.sv
module wdg_fault_policy
  import wfp_pkg::*;
#(
  parameter int START_CYC = 4_096_000,
  parameter int UV_CYC    = 4_096_000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        test_pin_i,
  input  logic        reg_we_i,
  input  logic        reg_re_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [1:0]  reg_wdata_i,
  input  logic [1:0]  op_mode_i,
  input  logic [3:0]  wd_fault_i,
  input  logic        uv_i,
  output logic        rst_req_o,
  output logic        irq_o,
  output logic        failsafe_o,
  output logic        restart_o,
  output logic        dev_mode_o,
  output logic        irq_flag_o,
  output logic [2:0]  rst_src_o
);
  logic dev_q, irq_en, uv_rise, uv_long, status_rd;

  assign status_rd = reg_re_i && (reg_addr_i == ADDR_STATUS);

  wfp_dev_latch #(.START_CYC(START_CYC)) u_latch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .test_pin_i (test_pin_i),
    .reg_we_i   (reg_we_i),
    .reg_addr_i (reg_addr_i),
    .reg_wdata_i(reg_wdata_i),
    .dev_q_o    (dev_q),
    .irq_en_o   (irq_en)
  );

  wfp_uv_qual #(.UV_CYC(UV_CYC)) u_uv (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .uv_i     (uv_i),
    .uv_rise_o(uv_rise),
    .uv_long_o(uv_long)
  );

  wfp_fault_route u_route (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wd_fault_i (wd_fault_i),
    .op_mode_i  (op_mode_i),
    .dev_q_i    (dev_q),
    .uv_rise_i  (uv_rise),
    .uv_long_i  (uv_long),
    .status_rd_i(status_rd),
    .rst_req_o  (rst_req_o),
    .failsafe_o (failsafe_o),
    .restart_o  (restart_o),
    .irq_flag_o (irq_flag_o),
    .rst_src_o  (rst_src_o)
  );

  assign dev_mode_o = dev_q;
  assign irq_o      = irq_flag_o && irq_en;
endmodule

// File: rtl/wfp_checker.sv
module wfp_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       reg_we_i,
  input logic [1:0] reg_addr_i,
  input logic [1:0] reg_wdata_i,
  input logic [1:0] op_mode_i,
  input logic [3:0] wd_fault_i,
  input logic       uv_i,
  input logic       rst_req_o,
  input logic       failsafe_o,
  input logic       restart_o,
  input logic       dev_mode_o,
  input logic       irq_flag_o,
  input logic [2:0] rst_src_o
);
  logic low_pw;
  assign low_pw = (op_mode_i == 2'd1) || (op_mode_i == 2'd2);

  a_r1_dev_fault_to_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_mode_o && !low_pw && (|wd_fault_i) && !uv_i) |=> (!rst_req_o && irq_flag_o));

  a_r2_cause_recorded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wd_fault_i) |=> (rst_src_o != 3'd0));

  a_r4_dev_no_failsafe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_mode_o && !low_pw && !uv_i) |=> !failsafe_o);

  a_r5_failsafe_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    failsafe_o |-> ($past(uv_i) || $past(|wd_fault_i)));

  a_r6_restart_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |-> ($past(uv_i) && rst_req_o));

  a_r9_mode_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 2'd1 && !reg_wdata_i[0]) |=> !dev_mode_o);

  a_r11_lowpower_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (low_pw && (|wd_fault_i)) |=> rst_req_o);
endmodule

bind wdg_fault_policy wfp_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .op_mode_i  (op_mode_i),
  .wd_fault_i (wd_fault_i),
  .uv_i       (uv_i),
  .rst_req_o  (rst_req_o),
  .failsafe_o (failsafe_o),
  .restart_o  (restart_o),
  .dev_mode_o (dev_mode_o),
  .irq_flag_o (irq_flag_o),
  .rst_src_o  (rst_src_o)
);

// File: tb/tb_wdg_fault_policy.sv
`timescale 1ns/1ps
module tb_wdg_fault_policy;
  localparam int START_CYC = 40;
  localparam int UV_CYC    = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic test_pin_i = 1'b0, reg_we_i = 1'b0, reg_re_i = 1'b0, uv_i = 1'b0;
  logic [1:0] reg_addr_i = '0, reg_wdata_i = '0, op_mode_i = '0;
  logic [3:0] wd_fault_i = '0;
  logic rst_req_o, irq_o, failsafe_o, restart_o, dev_mode_o, irq_flag_o;
  logic [2:0] rst_src_o;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wdg_fault_policy #(.START_CYC(START_CYC), .UV_CYC(UV_CYC)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .test_pin_i(test_pin_i), .reg_we_i(reg_we_i),
    .reg_re_i(reg_re_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .op_mode_i(op_mode_i), .wd_fault_i(wd_fault_i), .uv_i(uv_i),
    .rst_req_o(rst_req_o), .irq_o(irq_o), .failsafe_o(failsafe_o),
    .restart_o(restart_o), .dev_mode_o(dev_mode_o), .irq_flag_o(irq_flag_o),
    .rst_src_o(rst_src_o));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic tp);
    @(negedge clk);
    rst_ni = 1'b0; reg_we_i = 0; reg_re_i = 0; wd_fault_i = '0; uv_i = 0;
    op_mode_i = 2'd0; test_pin_i = tp;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [1:0] d);
    reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 0;
  endtask

  task automatic rd_status();
    reg_re_i = 1; reg_addr_i = 2'd2;
    @(negedge clk);
    reg_re_i = 0;
  endtask

  task automatic fault(input logic [3:0] v, input logic [1:0] m);
    wd_fault_i = v; op_mode_i = m;
    @(negedge clk);
    wd_fault_i = '0;
  endtask

  function automatic int cause_of(input logic [3:0] v);
    int c = 0;
    for (int i = 0; i < 4; i++) if (v[i]) c = 2 + i;
    return c;
  endfunction

  task automatic random_phase(input bit dev, input bit en, input int n);
    int exp_src, exp_flag;
    rd_status();
    exp_src = 0; exp_flag = 0;
    for (int k = 0; k < n; k++) begin
      logic [3:0] v;
      logic [1:0] m;
      bit lp, de, any;
      v = ($urandom % 2) ? 4'($urandom) : 4'd0;
      m = 2'($urandom);
      lp = (m == 2'd1) || (m == 2'd2);
      de = dev && !lp;
      any = |v;
      fault(v, m);
      if (any) exp_src = cause_of(v);
      if (any && de) exp_flag = 1;
      chk(dev ? "R1/R11 rand rst" : "R3/R11 rand rst", rst_req_o, int'(any && !de));
      chk(dev ? "R4 rand failsafe" : "R3 rand failsafe", failsafe_o, int'(any && !de && m == 2'd3));
      chk("R2 rand cause", rst_src_o, exp_src);
      chk("R12 rand irq", irq_o, exp_flag & int'(en));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // reset state
    do_reset(1'b0);
    chk("R2 reset cause", rst_src_o, 1);
    chk("R2 reset rst_req", rst_req_o, 0);
    chk("R8 reset dev", dev_mode_o, 0);
    chk("R12 reset flag", irq_flag_o, 0);
    @(negedge clk);
    // normal handling
    fault(4'b0001, 2'd0);
    chk("R3 ovf reset", rst_req_o, 1);
    chk("R3 ovf no failsafe", failsafe_o, 0);
    chk("R2 ovf cause", rst_src_o, 2);
    @(negedge clk);
    chk("R3 pulse ends", rst_req_o, 0);
    fault(4'b0010, 2'd3);
    chk("R3 restart failsafe", failsafe_o, 1);
    chk("R2 window cause", rst_src_o, 3);
    rd_status();
    chk("R2 read clears", rst_src_o, 0);
    fault(4'b0101, 2'd0);
    chk("R2 priority", rst_src_o, 4);
    // late arming
    do_reset(1'b0);
    repeat (START_CYC + 5) @(negedge clk);
    wr(2'd0, 2'b01);
    chk("R7 late arm", dev_mode_o, 0);
    // arming after another write
    do_reset(1'b0);
    wr(2'd3, 2'b00);
    wr(2'd0, 2'b01);
    chk("R7 arm after other write", dev_mode_o, 0);
    // arming on second special write
    do_reset(1'b0);
    wr(2'd0, 2'b00);
    wr(2'd0, 2'b01);
    chk("R7 second special write", dev_mode_o, 0);
    // valid arming
    do_reset(1'b0);
    wr(2'd0, 2'b01);
    chk("R7 arm ok", dev_mode_o, 1);
    fault(4'b0001, 2'd0);
    chk("R1 dev no reset", rst_req_o, 0);
    chk("R1 dev flag", irq_flag_o, 1);
    chk("R12 irq on", irq_o, 1);
    chk("R2 dev cause", rst_src_o, 2);
    fault(4'b1000, 2'd3);
    chk("R4 no failsafe", failsafe_o, 0);
    chk("R2 startup cause", rst_src_o, 5);
    wr(2'd1, 2'b01);
    chk("R9 confirm keeps", dev_mode_o, 1);
    chk("R12 irq gated", irq_o, 0);
    rd_status();
    chk("R12 read clears flag", irq_flag_o, 0);
    fault(4'b0001, 2'd1);
    chk("R11 standby reset", rst_req_o, 1);
    chk("R11 standby flag", irq_flag_o, 0);
    // long undervoltage in dev mode
    op_mode_i = 2'd0;
    uv_i = 1;
    @(negedge clk);
    chk("R6 uv reset", rst_req_o, 1);
    chk("R4 uv restart in dev", restart_o, 1);
    chk("R6 uv cause", rst_src_o, 6);
    begin
      int early = 0;
      for (int k = 2; k < UV_CYC; k++) begin
        @(negedge clk);
        early |= int'(failsafe_o);
      end
      chk("R5 no early failsafe", early, 0);
      @(negedge clk);
      chk("R5 failsafe at limit", failsafe_o, 1);
      @(negedge clk);
      chk("R5 failsafe once", failsafe_o, 0);
    end
    uv_i = 0;
    @(negedge clk);
    random_phase(1'b1, 1'b0, 200);
    // exit and no re-entry
    wr(2'd1, 2'b10);
    chk("R9 exit", dev_mode_o, 0);
    wr(2'd0, 2'b01);
    chk("R10 no re-arm", dev_mode_o, 0);
    fault(4'b0001, 2'd0);
    chk("R10 reset after exit", rst_req_o, 1);
    random_phase(1'b0, 1'b1, 200);
    // test pin
    do_reset(1'b1);
    @(negedge clk);
    test_pin_i = 0;
    chk("R8 pin entry", dev_mode_o, 1);
    @(negedge clk);
    chk("R8 pin low later", dev_mode_o, 1);
    do_reset(1'b1);
    @(negedge clk);
    wr(2'd1, 2'b00);
    chk("R9 exit with pin high", dev_mode_o, 0);
    do_reset(1'b0);
    @(negedge clk);
    test_pin_i = 1;
    repeat (3) @(negedge clk);
    chk("R8 late pin ignored", dev_mode_o, 0);
    test_pin_i = 0;
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule